// File: doc/BRIEF.md
# Paged Serial Memory Write Sequencer

This block sits behind the byte-level front end of a two-wire serial memory target. It turns received bytes and bus events into array operations. A write transaction carries two address bytes and then up to a page of data bytes. The data bytes are collected in a one-page staging buffer. On a stop they are copied into the array during a self-timed interval, and a busy flag is held for that whole interval. A read transaction streams bytes from a persistent address pointer. That pointer survives between transactions, so current-address, random and sequential reads all work.

Write and read transactions advance the pointer differently. During writes, only the in-page offset bits advance, so the write wraps inside one page. During reads, the whole address advances and wraps from the top of the array to zero. A write-protect input, sampled at the stop, suppresses the commit. While busy is high, every bus event is ignored, and the front end is expected to refuse the target address.

The array is an inferred synchronous RAM of `2**ADDR_W` bytes. The full-size build uses `ADDR_W = 14`, which gives 16,384 bytes in 256 pages of 64. The default parameter set is smaller, to keep elaboration light. `WR_CYCLES` must be at least the page size.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` and `tx_valid` are low.
- R2: The write address is the low `ADDR_W` bits of {first address byte, second address byte}. Bits of the first byte above that width have no effect on where data lands.
- R3: After each data byte, only the low `PAGE_W` bits of the pointer increment. Past the last offset of a page they wrap to offset 0 of the same page, and the page bits never change during a write.
- R4: When more than a page of data bytes is sent, each offset holds the last byte written to it.
- R5: The array is modified only after a stop that ends a write with at least one data byte. `busy` rises in the cycle after that stop and stays high for exactly `WR_CYCLES` cycles. A repeated start before the stop discards the staged bytes.
- R6: While `busy` is high, `bus_start`, `bus_stop`, `rx_valid` and `tx_req` have no effect. No read data is produced, and neither the array nor the pointer changes.
- R7: Only offsets that received a data byte are modified by a commit. Other bytes of the page keep their contents.
- R8: The pointer keeps, between transactions, the address after the last byte accessed. A read that sends no address returns the byte at the pointer.
- R9: A write that stops after only the two address bytes loads the pointer and starts no busy interval. A start with the read direction then reads from that address.
- R10: During reads the full address increments, and after address `2**ADDR_W-1` the next byte comes from address 0.
- R11: If `wp` is high when the stop arrives, no busy interval starts and the array is unchanged.
- R12: Each accepted `tx_req` produces `tx_valid` high for one cycle, in the next cycle, with the byte at the pointer in `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp | input | 1 | Write protect, high inhibits commits |
| bus_start | input | 1 | Pulse: start or repeated start addressed to this target |
| bus_rd | input | 1 | Direction that goes with `bus_start`, 1 = read |
| bus_stop | input | 1 | Pulse: stop condition |
| rx_valid | input | 1 | Pulse: a byte was received in a write transaction |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Pulse: front end needs the next read byte |
| tx_valid | output | 1 | Read byte is present on `tx_data` |
| tx_data | output | 8 | Read byte |
| busy | output | 1 | Self-timed write interval in progress |

## Verification
The bench builds the block with `ADDR_W = 10`, `PAGE_W = 6` and `WR_CYCLES = 80`. That gives 16 pages of 64 bytes. With these values the whole array can be filled with known data and read across its top-to-zero wrap in a few thousand cycles. The busy interval is short enough to time exactly on every commit. Two bits of the first address byte are live, so setting the ignored upper bits shows that they have no effect. A full page and a 70-byte overrun exercise the in-page wrap and the overwrite.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR_HI,
    SQ_ADDR_LO,
    SQ_DATA,
    SQ_READ
  } seq_state_e;

endpackage

// File: rtl/pwc_seq.sv
module pwc_seq
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy,
  input  logic                     wp,
  input  logic                     bus_start,
  input  logic                     bus_rd,
  input  logic                     bus_stop,
  input  logic                     rx_valid,
  input  byte_t                    rx_data,
  input  logic                     tx_req,
  output logic                     ev_clear,
  output logic                     ev_store,
  output logic [PAGE_W-1:0]        store_idx,
  output byte_t                    store_data,
  output logic                     ev_commit,
  output logic [ADDR_W-PAGE_W-1:0] commit_page,
  output logic                     ev_read,
  output logic [ADDR_W-1:0]        read_addr
);

  localparam int PN_W = ADDR_W - PAGE_W;

  seq_state_e        state;
  logic [ADDR_W-1:0] ptr;
  byte_t             hi_q;
  logic              got_data;

  function automatic logic [ADDR_W-1:0] assemble(input byte_t hi, input byte_t lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] in_page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] off;
    off = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], off};
  endfunction

  function automatic logic [ADDR_W-1:0] array_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic open_cycle;
  assign open_cycle = !busy && !bus_stop && !bus_start;

  assign ev_clear    = !busy && !bus_stop && bus_start && !bus_rd;
  assign ev_store    = open_cycle && (state == SQ_DATA) && rx_valid;
  assign ev_read     = open_cycle && (state == SQ_READ) && tx_req;
  assign ev_commit   = !busy && bus_stop && (state == SQ_DATA) && got_data && !wp;
  assign store_idx   = ptr[PAGE_W-1:0];
  assign store_data  = rx_data;
  assign commit_page = ptr[ADDR_W-1:PAGE_W];
  assign read_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ptr      <= '0;
      hi_q     <= '0;
      got_data <= 1'b0;
    end else if (!busy) begin
      if (bus_stop) begin
        state    <= SQ_IDLE;
        got_data <= 1'b0;
      end else if (bus_start) begin
        state    <= bus_rd ? SQ_READ : SQ_ADDR_HI;
        got_data <= 1'b0;
      end else begin
        case (state)
          SQ_ADDR_HI: if (rx_valid) begin
            hi_q  <= rx_data;
            state <= SQ_ADDR_LO;
          end
          SQ_ADDR_LO: if (rx_valid) begin
            ptr   <= assemble(hi_q, rx_data);
            state <= SQ_DATA;
          end
          SQ_DATA: if (rx_valid) begin
            ptr      <= in_page_next(ptr);
            got_data <= 1'b1;
          end
          SQ_READ: if (tx_req) ptr <= array_next(ptr);
          default: ;
        endcase
      end
    end
  end

  // R6: the sequencer sits idle for the whole self-timed interval
  p_idle_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state == SQ_IDLE));

  // R3: a data byte never moves the page bits
  p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R10: read past the top of the array lands on zero
  p_read_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read && (ptr == {ADDR_W{1'b1}})) |=> (ptr == '0));

  logic [PN_W-1:0] unused_pn;
  assign unused_pn = commit_page;

endmodule

// File: rtl/pwc_buf.sv
module pwc_buf
  import pwc_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] widx,
  input  byte_t             wdata,
  input  logic [PAGE_W-1:0] ridx,
  output byte_t             rdata,
  output logic              rvalid
);

  localparam int PAGE_BYTES = 1 << PAGE_W;

  byte_t                 data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (wr) data_q[widx] <= wdata;
  end

  for (genvar e = 0; e < PAGE_BYTES; e++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mask_q[e] <= 1'b0;
      else if (clr)                                mask_q[e] <= 1'b0;
      else if (wr && (widx == PAGE_W'(e)))         mask_q[e] <= 1'b1;
    end
  end

  assign rdata  = data_q[ridx];
  assign rvalid = mask_q[ridx];

endmodule

// File: rtl/pwc_commit.sv
module pwc_commit
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [ADDR_W-PAGE_W-1:0] page_in,
  input  byte_t                    buf_rdata,
  input  logic                     buf_rvalid,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic                     busy,
  output logic                     ram_we,
  output logic [ADDR_W-1:0]        ram_waddr,
  output byte_t                    ram_wdata
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TW         = $clog2(WR_CYCLES + 1);

  logic [TW-1:0]           tmr;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                    last_cycle;
  logic                    in_sweep;

  assign last_cycle = (tmr == TW'(WR_CYCLES - 1));
  assign in_sweep   = busy && (tmr < TW'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      page_q <= '0;
    end else if (go && !busy) begin
      busy   <= 1'b1;
      tmr    <= '0;
      page_q <= page_in;
    end else if (busy) begin
      if (last_cycle) busy <= 1'b0;
      else            tmr  <= tmr + 1'b1;
    end
  end

  assign buf_idx   = tmr[PAGE_W-1:0];
  assign ram_we    = in_sweep && buf_rvalid;
  assign ram_waddr = {page_q, buf_idx};
  assign ram_wdata = buf_rdata;

  // R5: the interval cannot end before its last counted cycle
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cycle) |=> busy);

endmodule

// File: rtl/pwc_array.sv
module pwc_array
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output byte_t             rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp,
  input  logic       bus_start,
  input  logic       bus_rd,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy
);

  localparam int PN_W = ADDR_W - PAGE_W;

  logic              ev_clear, ev_store, ev_commit, ev_read;
  logic [PAGE_W-1:0] store_idx, sweep_idx;
  byte_t             store_data, sweep_data;
  logic              sweep_valid;
  logic [PN_W-1:0]   commit_page;
  logic [ADDR_W-1:0] read_addr, ram_waddr;
  logic              ram_we;
  byte_t             ram_wdata, ram_rdata;

  pwc_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wp(wp),
    .bus_start(bus_start), .bus_rd(bus_rd), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req),
    .ev_clear(ev_clear), .ev_store(ev_store), .store_idx(store_idx),
    .store_data(store_data), .ev_commit(ev_commit), .commit_page(commit_page),
    .ev_read(ev_read), .read_addr(read_addr)
  );

  pwc_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(ev_clear), .wr(ev_store),
    .widx(store_idx), .wdata(store_data), .ridx(sweep_idx),
    .rdata(sweep_data), .rvalid(sweep_valid)
  );

  pwc_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(ev_commit), .page_in(commit_page),
    .buf_rdata(sweep_data), .buf_rvalid(sweep_valid), .buf_idx(sweep_idx),
    .busy(busy), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  pwc_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ev_read), .raddr(read_addr), .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= ev_read;
  end

  assign tx_data = ram_rdata;

  // R5: a busy interval only ever opens right after a stop
  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  // R11: a stop seen under write protect never opens an interval
  p_wp_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  // R12: read data only follows a request made one cycle earlier
  p_txv_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));

  // R6: the array is never written outside the busy interval
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

endmodule

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;

  localparam int AW    = 10;
  localparam int PW    = 6;
  localparam int WR    = 80;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp = 1'b0, bus_start = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
  logic       rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid, busy;
  logic [7:0] tx_data;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .bus_start(bus_start), .bus_rd(bus_rd),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] pend [PAGE];
  bit         pmask [PAGE];
  int         pcount;
  int         mptr;
  logic [7:0] expq [$];
  string      expr [$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each produced read byte with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected read byte actual=%0h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        string r;
        e = expq.pop_front();
        r = expr.pop_front();
        if (tx_data !== e) begin
          errors++;
          $display("FAIL %s read byte actual=%0h expected=%0h", r, tx_data, e);
        end
      end
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; cyc(); rx_valid = 1'b0; cyc();
  endtask

  task automatic start_pulse(input bit rd);
    bus_rd = rd; bus_start = 1'b1; cyc(); bus_start = 1'b0; cyc();
  endtask

  task automatic stop_pulse();
    bus_stop = 1'b1; cyc(); bus_stop = 1'b0;
  endtask

  // start + address bytes + n data bytes, tracked in the pending model
  task automatic write_txn(input int addr, input int n, input int seed, input logic [7:0] junk);
    start_pulse(1'b0);
    for (int i = 0; i < PAGE; i++) pmask[i] = 0;
    pcount = 0;
    send_byte(8'((addr >> 8) & 8'hFF) | junk);
    send_byte(8'(addr & 8'hFF));
    mptr = addr % DEPTH;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed + i * 7) & 8'hFF);
      send_byte(d);
      pend[mptr % PAGE] = d;
      pmask[mptr % PAGE] = 1;
      mptr = (mptr / PAGE) * PAGE + ((mptr + 1) % PAGE);
      pcount++;
    end
  endtask

  task automatic apply_pending();
    for (int i = 0; i < PAGE; i++)
      if (pmask[i]) mem_m[(mptr / PAGE) * PAGE + i] = pend[i];
  endtask

  task automatic check_busy_len(input string req);
    int cnt = 0;
    while (busy && cnt < 1000) begin cnt++; cyc(); end
    chk(req, cnt, WR);
  endtask

  task automatic check_no_busy(input string req);
    int seen = 0;
    for (int i = 0; i < 4; i++) begin if (busy) seen++; cyc(); end
    chk(req, seen, 0);
  endtask

  task automatic commit_write(input int addr, input int n, input int seed, input string req);
    write_txn(addr, n, seed, 8'h00);
    stop_pulse();
    apply_pending();
    check_busy_len(req);
  endtask

  // reads n bytes from the current pointer; start already issued or not
  task automatic read_bytes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      expq.push_back(mem_m[mptr]);
      expr.push_back(req);
      mptr = (mptr + 1) % DEPTH;
      tx_req = 1'b1; cyc(); tx_req = 1'b0;
      chk({req, " R12 valid"}, int'(tx_valid), 1);
      cyc();
    end
  endtask

  task automatic cur_read(input int n, input string req);
    start_pulse(1'b1);
    read_bytes(n, req);
    stop_pulse(); cyc();
  endtask

  task automatic rand_read(input int addr, input int n, input string req);
    write_txn(addr, 0, 0, 8'h00);
    start_pulse(1'b1);
    read_bytes(n, req);
    stop_pulse(); cyc();
  endtask

  initial begin
    int guard = 0;
    while (guard < 200000) begin @(posedge clk); guard++; end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", guard);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 busy", int'(busy), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);

    // fill every page with known data, timing each busy interval (R5)
    for (int p = 0; p < DEPTH / PAGE; p++) commit_write(p * PAGE, PAGE, p * 13 + 1, "R5 busy length");

    // R10: a read starting at 0 runs through the top and back to 0
    rand_read(0, DEPTH + 2, "R10 full sweep");
    // R10: explicit wrap at the top
    rand_read(DEPTH - 2, 4, "R10 top wrap");

    // R2: upper bits of the first address byte are ignored
    write_txn(12'h2A5, 1, 8'h5C, 8'hFC);
    stop_pulse(); apply_pending(); check_busy_len("R2 busy");
    rand_read(12'h2A4, 3, "R2 address assembly");

    // R3: start near the page end, wrap to its start
    commit_write(5 * PAGE + 60, 8, 8'h91, "R3 busy");
    rand_read(5 * PAGE, PAGE, "R3 in-page wrap");

    // R4: overrun of a page, later bytes win
    commit_write(7 * PAGE, PAGE + 6, 8'h20, "R4 busy");
    rand_read(7 * PAGE, PAGE, "R4 overwrite");

    // R7: partial page, neighbours unchanged
    commit_write(9 * PAGE + 20, 3, 8'hE0, "R7 busy");
    rand_read(9 * PAGE + 18, 7, "R7 partial page");

    // R8: pointer after a write is the address after the last byte
    commit_write(3 * PAGE + 10, 2, 8'h33, "R8 busy");
    cur_read(2, "R8 current read after write");
    cur_read(2, "R8 current read after read");

    // R9: address-only write loads the pointer, no interval
    write_txn(11 * PAGE + 5, 0, 0, 8'h00);
    stop_pulse(); cyc();
    check_no_busy("R9 no busy on address-only write");
    cur_read(2, "R9 read from loaded address");

    // R11: protected write leaves the array untouched
    wp = 1'b1;
    write_txn(2 * PAGE, 4, 8'hAA, 8'h00);
    stop_pulse();
    check_no_busy("R11 no busy under protect");
    wp = 1'b0;
    rand_read(2 * PAGE, 5, "R11 array unchanged");

    // R5: repeated start before stop discards the staged bytes
    write_txn(4 * PAGE, 3, 8'h77, 8'h00);
    start_pulse(1'b1);
    read_bytes(2, "R5 read after discarded data");
    stop_pulse(); cyc();
    check_no_busy("R5 no commit without stop");
    rand_read(4 * PAGE, 4, "R5 staged bytes discarded");

    // R6: bus activity during the busy interval is ignored
    write_txn(6 * PAGE + 8, 2, 8'h4E, 8'h00);
    stop_pulse();
    apply_pending();
    chk("R6 busy raised", int'(busy), 1);
    bus_rd = 1'b0; bus_start = 1'b1; cyc(); bus_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rx_data = 8'hC3; rx_valid = 1'b1; cyc(); rx_valid = 1'b0;
    end
    bus_stop = 1'b1; cyc(); bus_stop = 1'b0;
    bus_rd = 1'b1; bus_start = 1'b1; cyc(); bus_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tx_req = 1'b1; cyc(); tx_req = 1'b0;
      chk("R6 no read data while busy", int'(tx_valid), 0);
    end
    while (busy) cyc();
    cyc();
    cur_read(1, "R6 pointer unchanged by ignored traffic");
    rand_read(6 * PAGE, PAGE, "R6 array unchanged by ignored traffic");

    repeat (4) cyc();
    chk("R12 scoreboard drained", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule